// File: doc/BRIEF.md
# Two-way mailbox register bank

The block holds a small set of byte mailboxes that carry messages between a host processor and a local audio processor, which run on one shared clock. Each mailbox index has two independent registers. The inbound register is written by the host and read by the local side. The outbound register is written by the local side and read by the host. Each side has its own bus: a port index, a write strobe, a read strobe and a data byte in each direction. A side therefore never sees its own writes. A read at a given index always returns whatever the opposite side last stored there.

The local side can also empty its inbound mailboxes without any help from the host. It does this through a set of clear strobes, and each strobe covers a fixed group of neighbouring ports. With the default setting of four ports in groups of two, strobe bit 0 covers ports 0 and 1 and strobe bit 1 covers ports 2 and 3. Read data is registered. It is updated on the clock edge that samples a read strobe and holds its value at all other times. This fixes the result of a read that lands in the same cycle as the opposite side's write: the read returns the value stored before that write.

Top module: `mbox_bank`

## Requirements
- R1: After reset, all eight stored values are 0x00, and both read data outputs are 0x00.
- R2: A byte that the host writes at index p is returned on `loc_rdata` by the next local read of index p. That read data appears on the clock edge that samples `loc_rd`.
- R3: A byte that the local side writes at index p is returned on `host_rdata` by the next host read of index p. That read data appears on the clock edge that samples `host_rd`.
- R4: A side's own write has no effect on what that same side reads. A host read of index p returns the local-written value, and a local read of index p returns the host-written value.
- R5: While `loc_clr` bit 0 is high on a clock edge, the inbound values of ports 0 and 1 become 0x00, and ports 2 and 3 keep their values.
- R6: While `loc_clr` bit 1 is high on a clock edge, the inbound values of ports 2 and 3 become 0x00, and ports 0 and 1 keep their values.
- R7: The clear strobes have no effect on the outbound (local-to-host) values.
- R8: A read in the same cycle as the opposite side's write to the same index returns the value stored before that write. The next read of that index returns the new value.
- R9: If a host write and the clear strobe that covers the same port arrive in the same cycle, the host write is stored. The other ports in that group are still cleared.
- R10: While a side's read strobe is low, that side's read data output keeps its value, even when the stored values change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_idx | input | IDX_W (2) | Host-side port index |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DATA_W (8) | Host write byte |
| host_rdata | output | DATA_W (8) | Outbound value read by the host, registered |
| loc_idx | input | IDX_W (2) | Local-side port index |
| loc_wr | input | 1 | Local write strobe |
| loc_rd | input | 1 | Local read strobe |
| loc_wdata | input | DATA_W (8) | Local write byte |
| loc_rdata | output | DATA_W (8) | Inbound value read by the local side, registered |
| loc_clr | input | NUM_CLR (2) | Group clear strobes for the inbound values |

## Verification
The bench uses the default build: four ports, 8-bit data and clear groups of two. This is the configuration whose group boundaries match R5 and R6. With only eight registers, the bench can sweep every port in both directions through a set of data patterns and keep a full expected model of both register banks. It then reads the whole bank back after every clear, collision and priority case. As a result, a stray write, a wrong group boundary or a clear that leaks into the outbound registers shows up as a mismatch at a known index.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   // Clear-group number that governs a given port.
   function automatic int grp_of(input int port, input int grp_size);
      return port / grp_size;
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/mbox_cell.sv
module mbox_cell #(
   parameter int DATA_W  = 8,
   parameter bit HAS_CLR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              clr,
   output logic [DATA_W-1:0] q
);
   // A write takes priority over a clear that arrives in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (wr_en)
         q <= wdata;
      else if (HAS_CLR && clr)
         q <= '0;
   end
endmodule

// File: rtl/mbox_rdport.sv
module mbox_rdport #(
   parameter int NUM_PORTS = 4,
   parameter int DATA_W    = 8,
   localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             rd,
   input  logic [IDX_W-1:0]                 idx,
   input  logic [NUM_PORTS-1:0][DATA_W-1:0] vals,
   output logic [DATA_W-1:0]                rdata
);
   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_PORTS; i++)
         if (idx == IDX_W'(i)) sel = vals[i];
   end

   // The output register loads only when a read is sampled; otherwise it holds.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd)
         rdata <= sel;
   end
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
   import mbox_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int DATA_W    = 8,
   parameter int CLR_GROUP = 2,
   localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int NUM_CLR  = NUM_PORTS / CLR_GROUP
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W-1:0]   host_idx,
   input  logic               host_wr,
   input  logic               host_rd,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   input  logic [IDX_W-1:0]   loc_idx,
   input  logic               loc_wr,
   input  logic               loc_rd,
   input  logic [DATA_W-1:0]  loc_wdata,
   output logic [DATA_W-1:0]  loc_rdata,
   input  logic [NUM_CLR-1:0] loc_clr
);
   // Elaboration-time checks on the configuration.
   if (!is_pow2(NUM_PORTS) || NUM_PORTS < 2) begin : g_bad_ports
      $error("mbox_bank: NUM_PORTS must be a power of two, at least 2");
   end
   if (CLR_GROUP < 1 || (NUM_PORTS % CLR_GROUP) != 0) begin : g_bad_group
      $error("mbox_bank: CLR_GROUP must divide NUM_PORTS");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("mbox_bank: DATA_W must be positive");
   end

   logic [NUM_PORTS-1:0][DATA_W-1:0] h2l_q;  // host writes, local reads
   logic [NUM_PORTS-1:0][DATA_W-1:0] l2h_q;  // local writes, host reads

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam int GRP = grp_of(p, CLR_GROUP);

      logic h_we, l_we;
      assign h_we = host_wr && (host_idx == IDX_W'(p));
      assign l_we = loc_wr  && (loc_idx  == IDX_W'(p));

      mbox_cell #(.DATA_W(DATA_W), .HAS_CLR(1'b1)) u_in (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (h_we),
         .wdata (host_wdata),
         .clr   (loc_clr[GRP]),
         .q     (h2l_q[p])
      );

      mbox_cell #(.DATA_W(DATA_W), .HAS_CLR(1'b0)) u_out (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (l_we),
         .wdata (loc_wdata),
         .clr   (1'b0),
         .q     (l2h_q[p])
      );
   end

   mbox_rdport #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_loc_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (loc_rd),
      .idx   (loc_idx),
      .vals  (h2l_q),
      .rdata (loc_rdata)
   );

   mbox_rdport #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_host_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (host_rd),
      .idx   (host_idx),
      .vals  (l2h_q),
      .rdata (host_rdata)
   );
endmodule

// File: rtl/mbox_bank_chk.sv
module mbox_bank_chk #(
   parameter int NUM_PORTS = 4,
   parameter int DATA_W    = 8,
   parameter int CLR_GROUP = 2,
   localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int NUM_CLR  = NUM_PORTS / CLR_GROUP
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [IDX_W-1:0]                 host_idx,
   input logic                             host_wr,
   input logic                             host_rd,
   input logic [DATA_W-1:0]                host_wdata,
   input logic [DATA_W-1:0]                host_rdata,
   input logic [IDX_W-1:0]                 loc_idx,
   input logic                             loc_wr,
   input logic                             loc_rd,
   input logic [DATA_W-1:0]                loc_rdata,
   input logic [NUM_CLR-1:0]               loc_clr,
   input logic [NUM_PORTS-1:0][DATA_W-1:0] h2l_q,
   input logic [NUM_PORTS-1:0][DATA_W-1:0] l2h_q
);
   // R2 R8
   loc_rd_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loc_rd |=> loc_rdata == $past(h2l_q[loc_idx]));

   // R3 R8
   host_rd_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd |=> host_rdata == $past(l2h_q[host_idx]));

   // R10
   loc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !loc_rd |=> $stable(loc_rdata));

   // R10
   host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd |=> $stable(host_rdata));

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
      // R5 R6
      clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (loc_clr[p / CLR_GROUP] && !(host_wr && host_idx == IDX_W'(p)))
         |=> h2l_q[p] == '0);

      // R9
      hwr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (host_wr && host_idx == IDX_W'(p)) |=> h2l_q[p] == $past(host_wdata));

      // R4 R7
      out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(loc_wr && loc_idx == IDX_W'(p)) |=> $stable(l2h_q[p]));
   end
endmodule

bind mbox_bank mbox_bank_chk #(
   .NUM_PORTS (NUM_PORTS),
   .DATA_W    (DATA_W),
   .CLR_GROUP (CLR_GROUP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_idx   (host_idx),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .host_wdata (host_wdata),
   .host_rdata (host_rdata),
   .loc_idx    (loc_idx),
   .loc_wr     (loc_wr),
   .loc_rd     (loc_rd),
   .loc_rdata  (loc_rdata),
   .loc_clr    (loc_clr),
   .h2l_q      (h2l_q),
   .l2h_q      (l2h_q)
);

// File: tb/sim_mbox_bank.sv
`timescale 1ns/100ps
module sim_mbox_bank;
   localparam int NP = 4;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    host_idx = '0, loc_idx = '0;
   logic          host_wr = 1'b0, host_rd = 1'b0, loc_wr = 1'b0, loc_rd = 1'b0;
   logic [DW-1:0] host_wdata = '0, loc_wdata = '0;
   logic [DW-1:0] host_rdata, loc_rdata;
   logic [1:0]    loc_clr = '0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [DW-1:0] exp_in  [NP];
   logic [DW-1:0] exp_out [NP];

   always #2.5 clk = ~clk;

   mbox_bank u0 (
      .clk(clk), .rst_n(rst_n),
      .host_idx(host_idx), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .loc_idx(loc_idx), .loc_wr(loc_wr), .loc_rd(loc_rd),
      .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
      .loc_clr(loc_clr)
   );

   task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] expv);
      total++;
      if (got !== expv) begin
         bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, expv);
      end
   endtask

   task automatic hwrite(input int p, input logic [DW-1:0] v);
      host_idx = 2'(p); host_wdata = v; host_wr = 1'b1;
      @(negedge clk); host_wr = 1'b0;
      exp_in[p] = v;
   endtask

   task automatic lwrite(input int p, input logic [DW-1:0] v);
      loc_idx = 2'(p); loc_wdata = v; loc_wr = 1'b1;
      @(negedge clk); loc_wr = 1'b0;
      exp_out[p] = v;
   endtask

   task automatic lread(input int p, output logic [DW-1:0] v);
      loc_idx = 2'(p); loc_rd = 1'b1;
      @(negedge clk); loc_rd = 1'b0; v = loc_rdata;
   endtask

   task automatic hread(input int p, output logic [DW-1:0] v);
      host_idx = 2'(p); host_rd = 1'b1;
      @(negedge clk); host_rd = 1'b0; v = host_rdata;
   endtask

   task automatic sweep_check(input string req);
      logic [DW-1:0] v;
      for (int p = 0; p < NP; p++) begin
         lread(p, v); check(req, v, exp_in[p]);
         hread(p, v); check(req, v, exp_out[p]);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      logic [DW-1:0] v, old;
      logic [DW-1:0] pats [6];
      pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h55;
      pats[3] = 8'hAA; pats[4] = 8'h01; pats[5] = 8'h80;
      for (int p = 0; p < NP; p++) begin exp_in[p] = '0; exp_out[p] = '0; end

      repeat (3) @(negedge clk);
      // R1: outputs at reset, then the full bank after release
      check("R1", loc_rdata, 8'h00);
      check("R1", host_rdata, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      sweep_check("R1");

      // R2 R3: every port, both directions, several patterns
      for (int k = 0; k < 6; k++) begin
         for (int p = 0; p < NP; p++) begin
            hwrite(p, pats[k] ^ 8'(p * 37));
            lwrite(p, ~pats[k] ^ 8'(p * 11 + k));
         end
         for (int p = 0; p < NP; p++) begin
            lread(p, v); check("R2", v, exp_in[p]);
            hread(p, v); check("R3", v, exp_out[p]);
         end
      end

      // R4: own writes are invisible to the writer
      for (int p = 0; p < NP; p++) begin
         hwrite(p, 8'h5A + 8'(p));
         hread(p, v); check("R4", v, exp_out[p]);
         lwrite(p, 8'hC3 - 8'(p));
         lread(p, v); check("R4", v, exp_in[p]);
      end

      // R5 R7: group 0 clear
      for (int p = 0; p < NP; p++) begin hwrite(p, 8'h10 + 8'(p)); lwrite(p, 8'hE0 + 8'(p)); end
      loc_clr = 2'b01; @(negedge clk); loc_clr = 2'b00;
      exp_in[0] = 8'h00; exp_in[1] = 8'h00;
      sweep_check("R5 R7");

      // R6 R7: group 1 clear
      for (int p = 0; p < NP; p++) hwrite(p, 8'h20 + 8'(p));
      loc_clr = 2'b10; @(negedge clk); loc_clr = 2'b00;
      exp_in[2] = 8'h00; exp_in[3] = 8'h00;
      sweep_check("R6 R7");

      // R8: read colliding with opposite write returns the old value
      for (int p = 0; p < NP; p++) begin
         old = exp_in[p];
         host_idx = 2'(p); host_wdata = 8'h90 + 8'(p); host_wr = 1'b1;
         loc_idx = 2'(p); loc_rd = 1'b1;
         @(negedge clk); host_wr = 1'b0; loc_rd = 1'b0;
         exp_in[p] = 8'h90 + 8'(p);
         check("R8 collide loc", loc_rdata, old);
         lread(p, v); check("R8 after loc", v, exp_in[p]);

         old = exp_out[p];
         loc_idx = 2'(p); loc_wdata = 8'h70 + 8'(p); loc_wr = 1'b1;
         host_idx = 2'(p); host_rd = 1'b1;
         @(negedge clk); loc_wr = 1'b0; host_rd = 1'b0;
         exp_out[p] = 8'h70 + 8'(p);
         check("R8 collide host", host_rdata, old);
         hread(p, v); check("R8 after host", v, exp_out[p]);
      end

      // R9: write beats clear; the group partner is still cleared
      for (int p = 0; p < NP; p++) hwrite(p, 8'h33 + 8'(p));
      for (int p = 0; p < NP; p++) begin
         host_idx = 2'(p); host_wdata = 8'hB0 + 8'(p); host_wr = 1'b1;
         loc_clr = (p < 2) ? 2'b01 : 2'b10;
         @(negedge clk); host_wr = 1'b0; loc_clr = 2'b00;
         exp_in[p] = 8'hB0 + 8'(p);
         exp_in[p ^ 1] = 8'h00;
         lread(p, v); check("R9 write kept", v, exp_in[p]);
         lread(p ^ 1, v); check("R9 partner cleared", v, 8'h00);
         hwrite(p ^ 1, 8'h44);
      end

      // R10: read data holds while read strobe is low
      lread(2, old);
      hread(1, v);
      hwrite(2, ~old);
      lwrite(1, ~v);
      repeat (3) @(negedge clk);
      check("R10 loc", loc_rdata, old);
      check("R10 host", host_rdata, v);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule